// File: doc/BRIEF.md
# Difference-or-Zero Execution Unit

This unit executes a single fixed-point instruction. Given an instruction word and two signed register operands A and B, it works out B minus A. If A is greater than B in a signed comparison, it returns zero instead of the difference. It also computes the next value of the architectural status bits: a sticky summary-overflow bit, an overflow bit and a carry bit in the exception register, and the four-bit condition field 0. Two instruction bits decide which of these status bits are written.

Each valid instruction word is decoded. If it is not the difference-or-zero instruction, the unit raises a flag, makes no register write and leaves every status bit as it was. All outputs are registered, so each result appears one clock after the inputs are sampled. The caller supplies the current status bits and takes the updated values back. Register-file access and pipelining are handled outside the unit.

Top module: `dze_unit`

## Requirements
- R1: The instruction matches when instr[31:26]==31 and instr[9:1]==264. The other fields are RT=instr[25:21], OE=instr[10] and Rc=instr[0]. When a match is sampled with in_valid high, res_we is 1 and res_rt equals RT one clock later.
- R2: When A <= B (signed), res_data is B-A truncated to 32 bits, computed as ~A+B+1.
- R3: When A > B (signed), res_data is zero.
- R4: When OE=0, xer_so_out and xer_ov_out equal xer_so_in and xer_ov_in. When Rc=0, cr0_out equals cr0_in.
- R5: xer_ca_out always equals xer_ca_in, whatever the instruction form.
- R6: When OE=1, xer_ov_out is 1 exactly when the true difference B-A exceeds 0x7FFFFFFF. It is cleared in every other case, including the clamped case.
- R7: When OE=1, xer_so_out is xer_so_in OR the new overflow. The unit never clears a set summary-overflow bit.
- R8: When Rc=1, cr0_out is {LT,GT,EQ,SO} in bits 3..0. LT, GT and EQ compare the signed 32-bit result with zero, and exactly one of them is set. SO is the updated xer_so_out.
- R9: A valid instruction that does not match sets unmatched to 1 and res_we to 0, and passes every status bit through unchanged.
- R10: When in_valid is low, res_we and unmatched are 0 and every status bit passes through unchanged.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are valid |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | Operand A (signed) |
| opnd_b | input | 32 | Operand B (signed) |
| xer_so_in | input | 1 | Current summary-overflow bit |
| xer_ov_in | input | 1 | Current overflow bit |
| xer_ca_in | input | 1 | Current carry bit |
| cr0_in | input | 4 | Current condition field 0 {LT,GT,EQ,SO} |
| res_data | output | 32 | Result value for the target register |
| res_we | output | 1 | Target register write enable |
| res_rt | output | 5 | Target register index |
| xer_so_out | output | 1 | Updated summary-overflow bit |
| xer_ov_out | output | 1 | Updated overflow bit |
| xer_ca_out | output | 1 | Carry bit, passed through |
| cr0_out | output | 4 | Updated condition field 0 |
| unmatched | output | 1 | Valid instruction was not recognised |

## Verification
All outputs come from one register stage, so the result, write enable, flags and unmatched indication for inputs sampled at one rising edge are valid from that edge until the next one. The bench changes its inputs on the falling edge and waits for one rising edge. It then samples a quarter period later, before it drives anything new. This keeps every comparison in the cycle where the design's output changes. The expected values come from a table of hand-computed results and from a 64-bit model of the signed difference.

// File: rtl/dze_pkg.sv
package dze_pkg;

  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned CR_W      = 4;

  // Field layout of the instruction word, most significant field first.
  typedef struct packed {
    logic [5:0]           opcd;
    logic [REG_IDX_W-1:0] rt;
    logic [REG_IDX_W-1:0] ra;
    logic [REG_IDX_W-1:0] rb;
    logic                 oe;
    logic [8:0]           xo;
    logic                 rc;
  } dze_instr_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_field_t;

endpackage

// File: rtl/dze_decode.sv
module dze_decode
  import dze_pkg::*;
#(
  parameter int unsigned PRIM_OPC = 31,
  parameter int unsigned EXT_OPC  = 264
) (
  input  logic [INSTR_W-1:0]   instr,
  input  logic                 valid,
  output logic                 hit,
  output logic                 miss,
  output logic                 oe,
  output logic                 rc,
  output logic [REG_IDX_W-1:0] rt
);

  localparam logic [5:0] PRIM_V = PRIM_OPC[5:0];
  localparam logic [8:0] EXT_V  = EXT_OPC[8:0];

  dze_instr_t f;
  logic       unused_src_idx;

  assign f              = dze_instr_t'(instr);
  assign unused_src_idx = ^{f.ra, f.rb};

  assign hit  = valid && (f.opcd == PRIM_V) && (f.xo == EXT_V);
  assign miss = valid && !hit;
  assign oe   = f.oe;
  assign rc   = f.rc;
  assign rt   = f.rt;

endmodule

// File: rtl/dze_arith.sv
module dze_arith #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output logic              a_gt_b,
  output logic              pos_ovf
);

  localparam int unsigned EXT_W = DATA_W + 1;

  // Sign-extended B + ~A + 1, one bit wider than the operands.
  function automatic logic [EXT_W-1:0] wide_diff(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    logic [EXT_W-1:0] xe;
    logic [EXT_W-1:0] ye;
    xe = {x[DATA_W-1], x};
    ye = {y[DATA_W-1], y};
    return ye + ~xe + EXT_W'(1);
  endfunction

  function automatic logic sgt(input logic [DATA_W-1:0] x,
                               input logic [DATA_W-1:0] y);
    return $signed(x) > $signed(y);
  endfunction

  // Above the largest positive value: the wide sign is clear but the narrow sign is set.
  function automatic logic above_max(input logic [EXT_W-1:0] d);
    return !d[EXT_W-1] && d[DATA_W-1];
  endfunction

  logic [EXT_W-1:0] diff_w;

  assign diff_w  = wide_diff(a, b);
  assign a_gt_b  = sgt(a, b);
  assign result  = a_gt_b ? '0 : diff_w[DATA_W-1:0];
  assign pos_ovf = !a_gt_b && above_max(diff_w);

endmodule

// File: rtl/dze_flags.sv
module dze_flags
  import dze_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              hit,
  input  logic              oe,
  input  logic              rc,
  input  logic              pos_ovf,
  input  logic [DATA_W-1:0] result,
  input  logic              so_in,
  input  logic              ov_in,
  input  cr_field_t         cr_in,
  output logic              so_nxt,
  output logic              ov_nxt,
  output cr_field_t         cr_nxt
);

  function automatic cr_field_t compare_zero(input logic [DATA_W-1:0] r,
                                             input logic so);
    cr_field_t c;
    c.lt = r[DATA_W-1];
    c.eq = (r == '0);
    c.gt = !c.lt && !c.eq;
    c.so = so;
    return c;
  endfunction

  logic xer_upd;
  logic cr_upd;

  assign xer_upd = hit && oe;
  assign cr_upd  = hit && rc;

  always_comb begin
    ov_nxt = ov_in;
    so_nxt = so_in;
    if (xer_upd) begin
      ov_nxt = pos_ovf;
      so_nxt = so_in | pos_ovf;
    end
    cr_nxt = cr_upd ? compare_zero(result, so_nxt) : cr_in;
  end

endmodule

// File: rtl/dze_unit.sv
module dze_unit
  import dze_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PRIM_OPC = 31,
  parameter int unsigned EXT_OPC  = 264
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [DATA_W-1:0]    opnd_a,
  input  logic [DATA_W-1:0]    opnd_b,
  input  logic                 xer_so_in,
  input  logic                 xer_ov_in,
  input  logic                 xer_ca_in,
  input  logic [CR_W-1:0]      cr0_in,
  output logic [DATA_W-1:0]    res_data,
  output logic                 res_we,
  output logic [REG_IDX_W-1:0] res_rt,
  output logic                 xer_so_out,
  output logic                 xer_ov_out,
  output logic                 xer_ca_out,
  output logic [CR_W-1:0]      cr0_out,
  output logic                 unmatched
);

  // Named internal events, visible to the bound checker.
  logic                 dec_hit;
  logic                 dec_miss;
  logic                 dec_oe;
  logic                 dec_rc;
  logic [REG_IDX_W-1:0] dec_rt;
  logic [DATA_W-1:0]    calc_res;
  logic                 clamp_evt;
  logic                 ovf_evt;
  logic                 so_nxt;
  logic                 ov_nxt;
  cr_field_t            cr_nxt;

  dze_decode #(
    .PRIM_OPC(PRIM_OPC),
    .EXT_OPC (EXT_OPC)
  ) u_dec (
    .instr(instr),
    .valid(in_valid),
    .hit  (dec_hit),
    .miss (dec_miss),
    .oe   (dec_oe),
    .rc   (dec_rc),
    .rt   (dec_rt)
  );

  dze_arith #(.DATA_W(DATA_W)) u_alu (
    .a      (opnd_a),
    .b      (opnd_b),
    .result (calc_res),
    .a_gt_b (clamp_evt),
    .pos_ovf(ovf_evt)
  );

  dze_flags #(.DATA_W(DATA_W)) u_flg (
    .hit    (dec_hit),
    .oe     (dec_oe),
    .rc     (dec_rc),
    .pos_ovf(ovf_evt),
    .result (calc_res),
    .so_in  (xer_so_in),
    .ov_in  (xer_ov_in),
    .cr_in  (cr_field_t'(cr0_in)),
    .so_nxt (so_nxt),
    .ov_nxt (ov_nxt),
    .cr_nxt (cr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data   <= '0;
      res_we     <= 1'b0;
      res_rt     <= '0;
      xer_so_out <= 1'b0;
      xer_ov_out <= 1'b0;
      xer_ca_out <= 1'b0;
      cr0_out    <= '0;
      unmatched  <= 1'b0;
    end else begin
      res_data   <= dec_hit ? calc_res : '0;
      res_we     <= dec_hit;
      res_rt     <= dec_hit ? dec_rt : '0;
      xer_so_out <= so_nxt;
      xer_ov_out <= ov_nxt;
      xer_ca_out <= xer_ca_in;
      cr0_out    <= cr_nxt;
      unmatched  <= dec_miss;
    end
  end

endmodule

// File: rtl/dze_unit_chk.sv
module dze_unit_chk
  import dze_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [INSTR_W-1:0]   instr,
  input logic                 xer_so_in,
  input logic                 xer_ov_in,
  input logic                 xer_ca_in,
  input logic [DATA_W-1:0]    res_data,
  input logic                 res_we,
  input logic [REG_IDX_W-1:0] res_rt,
  input logic                 xer_so_out,
  input logic                 xer_ov_out,
  input logic                 xer_ca_out,
  input logic [CR_W-1:0]      cr0_out,
  input logic                 unmatched,
  input logic                 dec_hit,
  input logic                 clamp_evt,
  input logic                 ovf_evt
);

  // R1: a decoded match writes the RT field one clock later
  a_r1_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && dec_hit) |-> (res_we && res_rt == $past(instr[25:21])));

  // R3: the clamp event forces a zero result
  a_r3_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && dec_hit && clamp_evt) |-> (res_data == '0));

  // R5: carry is passed through untouched
  a_r5_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (xer_ca_out == $past(xer_ca_in)));

  // R6: clamped results with OE set clear overflow
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && dec_hit && instr[10] && clamp_evt) |-> !xer_ov_out);

  // R6: a newly raised overflow needs a positive-overflow event
  a_r6_ov_source: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && xer_ov_out && !$past(xer_ov_in)) |-> $past(ovf_evt));

  // R7: summary overflow is never cleared
  a_r7_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && xer_so_in) |-> xer_so_out);

  // R8: recorded condition has exactly one of LT, GT, EQ
  a_r8_cr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && dec_hit && instr[0]) |-> ($countones(cr0_out[3:1]) == 1));

  // R9: an unmatched instruction never writes
  a_r9_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
    unmatched |-> !res_we);

endmodule

bind dze_unit dze_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dze_unit_tb_top.sv
module dze_unit_tb_top;

  localparam int PERIOD = 10;
  localparam int NVEC   = 12;
  localparam int NRAND  = 300;

  // {A, B, expected result, expected positive overflow}
  localparam logic [96:0] VEC [NVEC] = '{
    {32'h00000001, 32'h00000002, 32'h00000001, 1'b0},
    {32'h00000001, 32'h00000000, 32'h00000000, 1'b0},
    {32'h00000002, 32'h00000008, 32'h00000006, 1'b0},
    {32'hEFFFFFFF, 32'h00000000, 32'h10000001, 1'b0},
    {32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1},
    {32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b0},
    {32'h80000000, 32'h00000000, 32'h80000000, 1'b1},
    {32'h00000005, 32'h00000005, 32'h00000000, 1'b0},
    {32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 1'b1},
    {32'hFFFFFFFF, 32'h7FFFFFFE, 32'h7FFFFFFF, 1'b0},
    {32'h80000000, 32'h80000000, 32'h00000000, 1'b0},
    {32'hFFFFFFF0, 32'hFFFFFFFF, 32'h0000000F, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        xer_so_in = 1'b0;
  logic        xer_ov_in = 1'b0;
  logic        xer_ca_in = 1'b0;
  logic [3:0]  cr0_in = '0;
  logic [31:0] res_data;
  logic        res_we;
  logic [4:0]  res_rt;
  logic        xer_so_out;
  logic        xer_ov_out;
  logic        xer_ca_out;
  logic [3:0]  cr0_out;
  logic        unmatched;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  dze_unit dut_i (.*);

  function automatic logic [31:0] mk_instr(input logic [4:0] rt, input logic oe,
                                           input logic rc);
    return {6'd31, rt, 5'd4, 5'd6, oe, 9'd264, rc};
  endfunction

  // Independent model: 64-bit signed difference.
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, d;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (sa > sb) return 33'd0;
    d = sb - sa;
    return {d > 64'sd2147483647, d[31:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic so, input logic ov,
                       input logic ca, input logic [3:0] cr);
    @(negedge clk);
    in_valid = v; instr = ins; opnd_a = a; opnd_b = b;
    xer_so_in = so; xer_ov_in = ov; xer_ca_in = ca; cr0_in = cr;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  // One matched operation in a given form, checked against expected res/ov.
  task automatic run_form(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] er, input logic eov,
                          input logic oe, input logic rc, input logic [4:0] rt);
    logic so_i, ov_i, ca_i, so_e, ov_e;
    logic [3:0] cr_i, cr_e;
    so_i = 1'($urandom); ov_i = 1'($urandom); ca_i = 1'($urandom);
    cr_i = 4'($urandom);
    drive(1'b1, mk_instr(rt, oe, rc), a, b, so_i, ov_i, ca_i, cr_i);
    ov_e = oe ? eov : ov_i;
    so_e = oe ? (so_i | eov) : so_i;
    cr_e = rc ? {er[31], !er[31] && er != 0, er == 0, so_e} : cr_i;
    chk("R1 we",     32'(res_we), 32'd1);
    chk("R1 rt",     32'(res_rt), 32'(rt));
    chk(($signed(a) > $signed(b)) ? "R3 result" : "R2 result", res_data, er);
    chk("R5 ca",     32'(xer_ca_out), 32'(ca_i));
    chk(oe ? "R6 ov" : "R4 ov", 32'(xer_ov_out), 32'(ov_e));
    chk(oe ? "R7 so" : "R4 so", 32'(xer_so_out), 32'(so_e));
    chk(rc ? "R8 cr0" : "R4 cr0", 32'(cr0_out), 32'(cr_e));
    chk("R9 unmatched", 32'(unmatched), 32'd0);
  endtask

  task automatic run_idle(input logic v, input logic [31:0] ins, input string req);
    logic so_i, ov_i, ca_i;
    logic [3:0] cr_i;
    so_i = 1'($urandom); ov_i = 1'($urandom); ca_i = 1'($urandom);
    cr_i = 4'($urandom);
    drive(v, ins, 32'h80000000, 32'h7FFFFFFF, so_i, ov_i, ca_i, cr_i);
    chk({req, " we"},   32'(res_we), 32'd0);
    chk({req, " flag"}, 32'(unmatched), 32'(v));
    chk({req, " so"},   32'(xer_so_out), 32'(so_i));
    chk({req, " ov"},   32'(xer_ov_out), 32'(ov_i));
    chk({req, " ca"},   32'(xer_ca_out), 32'(ca_i));
    chk({req, " cr0"},  32'(cr0_out), 32'(cr_i));
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R11: reset state with busy inputs
    in_valid = 1'b1; instr = mk_instr(5'd3, 1'b1, 1'b1);
    opnd_a = 32'd1; opnd_b = 32'd9; xer_so_in = 1'b1; xer_ov_in = 1'b1;
    xer_ca_in = 1'b1; cr0_in = 4'hF;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    chk("R11 res_data", res_data, 32'd0);
    chk("R11 res_we",   32'(res_we), 32'd0);
    chk("R11 status",   32'({xer_so_out, xer_ov_out, xer_ca_out, cr0_out, unmatched}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1; in_valid = 1'b0;

    // Table walk over all four forms (R2, R3, R6, R7, R8, R4)
    for (int i = 0; i < NVEC; i++) begin
      for (int f = 0; f < 4; f++) begin
        run_form(VEC[i][96:65], VEC[i][64:33], VEC[i][32:1], VEC[i][0],
                 f[1], f[0], 5'(i + f));
      end
    end

    // R7: sticky SO with OE set and no overflow
    drive(1'b1, mk_instr(5'd7, 1'b1, 1'b1), 32'd1, 32'd2, 1'b1, 1'b1, 1'b0, 4'h0);
    chk("R7 so kept", 32'(xer_so_out), 32'd1);
    chk("R6 ov cleared", 32'(xer_ov_out), 32'd0);
    chk("R8 cr0 so copy", 32'(cr0_out), 32'b0101);

    // R9: unmatched opcodes
    run_idle(1'b1, {6'd30, 5'd1, 5'd2, 5'd3, 1'b0, 9'd264, 1'b0}, "R9 bad primary");
    run_idle(1'b1, {6'd31, 5'd1, 5'd2, 5'd3, 1'b1, 9'd266, 1'b1}, "R9 bad extended");
    // R10: no valid
    run_idle(1'b0, mk_instr(5'd1, 1'b1, 1'b1), "R10 idle");

    // Random operands against the model
    for (int k = 0; k < NRAND; k++) begin
      logic [31:0] a, b;
      logic [32:0] m;
      a = $urandom; b = $urandom;
      if (k % 5 == 0) a = {a[31], 31'($urandom % 4)};
      if (k % 7 == 0) b = 32'h7FFFFFFF - 32'($urandom % 3);
      m = model(a, b);
      run_form(a, b, m[31:0], m[32], 1'($urandom), 1'($urandom), 5'($urandom));
    end

    // R11: reset in mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #(PERIOD/4);
    chk("R11 async", 32'({res_we, xer_so_out, xer_ov_out, xer_ca_out, cr0_out}), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule